// File: doc/BRIEF.md
# Per-Thread Program Counter Updater

This block keeps the program counter of one hardware thread in an interleaved multi-threaded core. One copy is placed for each thread. Every cycle it picks the thread's next fetch address from a fixed-priority set of events that other units raise. The events are reset, a trap entry for an exception, a return from a trap handler, an interrupt being taken, a branch resolved as taken, and a branch whose redirect has to wait for the thread's next issue slot. When none of these is active, the address moves forward by one 32-bit instruction each time the thread's instruction issues. The block does not compute branch targets. It does not store the trap vector or the saved exception PC, and it does not choose which thread issues. All of these arrive as inputs.

Every address the block loads is forced to a 4-byte boundary, because instructions are 32-bit aligned and there is no compressed format. A deferred branch stores its target in a small holding register. The stored target replaces the normal increment at the thread's next issue, unless a stronger redirect discards it first.

Top module: `pc_updater_thread`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes the `BOOT_ADDR` parameter with bits [1:0] cleared, and any held deferred branch is discarded. Reset outranks every other input.
- R2: With no event, no interrupt wait and no held deferred branch, a cycle with `issue_i` high adds 4 to the PC, modulo 2^32.
- R3: `exc_i` loads `tvec_i` into the PC at the next edge, whether or not `issue_i` is high. It outranks all inputs except reset, and it discards a held deferred branch.
- R4: `mret_i` loads `epc_i`. It ranks below `exc_i` and above every other event, and it discards a held deferred branch.
- R5: `irq_served_i` loads `tvec_i`. It ranks below `mret_i` and above both branch inputs, and it discards a held deferred branch.
- R6: `br_take_i` loads `br_target_i`. It ranks below `irq_served_i` and above `br_defer_i`, and it discards a held deferred branch.
- R7: `br_defer_i` leaves the PC unchanged in its own cycle and stores `br_target_i`, replacing any earlier stored target. At the first later cycle with `issue_i` high and no stronger event or wait, the PC takes the stored target in place of the increment, and the store is emptied.
- R8: While `irq_wait_i` is high without a stronger event, a cycle with `issue_i` high keeps the PC unchanged and keeps any stored deferred target.
- R9: A cycle with `issue_i` low and no event leaves the PC unchanged.
- R10: Bits [1:0] of the PC are zero after reset in every cycle, even when a target input has those bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | This thread's instruction issues in this cycle |
| br_take_i | input | 1 | Branch taken, redirect now |
| br_defer_i | input | 1 | Branch taken, redirect at the next issue slot |
| br_target_i | input | 32 | Branch target address |
| exc_i | input | 1 | Exception, enter the trap handler |
| tvec_i | input | 32 | Trap-vector base address |
| mret_i | input | 1 | Return from trap |
| epc_i | input | 32 | Saved exception PC |
| irq_wait_i | input | 1 | Interrupt pending but not yet taken |
| irq_served_i | input | 1 | Interrupt taken now |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the PC has a defined value before any property is enabled. They place no limit on how the event strobes combine, because the priority order makes every combination well defined. The stimulus therefore does not keep the events apart. Directed phases exercise each event alone, pairs that test the priority order, and targets with low bits set. A random phase then raises several events at once and holds deferred branches across cycles with no issue and across interrupt waits, with a reset in the middle of the run.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned PC_W       = 32;
    localparam int unsigned ALIGN_BITS = 2;
    localparam int unsigned STEP       = 1 << ALIGN_BITS;

    typedef logic [PC_W-1:0] pc_t;

    // Source chosen for the next PC, listed from strongest to weakest
    typedef enum logic [3:0] {
        NS_BOOT,
        NS_TRAP,
        NS_RET,
        NS_IRQ,
        NS_JUMP,
        NS_DEFER,
        NS_IDLE,
        NS_STALL,
        NS_RESUME,
        NS_STEP
    } nsel_e;

    typedef struct packed {
        logic boot;
        logic exc;
        logic ret;
        logic irq_srv;
        logic jmp;
        logic defer;
        logic issue;
        logic irq_wait;
    } ev_t;

    function automatic pc_t word_align(pc_t a);
        return {a[PC_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    function automatic logic is_redirect(nsel_e s);
        return (s == NS_TRAP) || (s == NS_RET) || (s == NS_IRQ) || (s == NS_JUMP);
    endfunction

endpackage

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter pc_t BOOT_ADDR = '0
) (
    input  ev_t   ev,
    input  pc_t   pc_q,
    input  logic  pend_vld,
    input  pc_t   pend_tgt,
    input  pc_t   tvec,
    input  pc_t   epc,
    input  pc_t   br_tgt,
    output nsel_e nsel,
    output pc_t   pc_d
);

    localparam pc_t BOOT_ALIGNED = word_align(BOOT_ADDR);

    always_comb begin
        if (ev.boot)                    nsel = NS_BOOT;
        else if (ev.exc)                nsel = NS_TRAP;
        else if (ev.ret)                nsel = NS_RET;
        else if (ev.irq_srv)            nsel = NS_IRQ;
        else if (ev.jmp)                nsel = NS_JUMP;
        else if (ev.defer)              nsel = NS_DEFER;
        else if (!ev.issue)             nsel = NS_IDLE;
        else if (ev.irq_wait)           nsel = NS_STALL;
        else if (pend_vld)              nsel = NS_RESUME;
        else                            nsel = NS_STEP;
    end

    always_comb begin
        unique case (nsel)
            NS_BOOT:   pc_d = BOOT_ALIGNED;
            NS_TRAP:   pc_d = word_align(tvec);
            NS_RET:    pc_d = word_align(epc);
            NS_IRQ:    pc_d = word_align(tvec);
            NS_JUMP:   pc_d = word_align(br_tgt);
            NS_RESUME: pc_d = pend_tgt;
            NS_STEP:   pc_d = pc_q + pc_t'(STEP);
            default:   pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcu_pend_latch.sv
module pcu_pend_latch
    import pcu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic drop,
    input  pc_t  tgt_in,
    output logic vld,
    output pc_t  tgt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            tgt_q <= '0;
        end else if (load) begin
            vld   <= 1'b1;
            tgt_q <= word_align(tgt_in);
        end else if (drop) begin
            vld   <= 1'b0;
        end
    end

endmodule

// File: rtl/pc_updater_thread.sv
module pc_updater_thread
    import pcu_pkg::*;
#(
    parameter logic [31:0] BOOT_ADDR = 32'h0000_0080
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_i,
    input  logic        br_take_i,
    input  logic        br_defer_i,
    input  logic [31:0] br_target_i,
    input  logic        exc_i,
    input  logic [31:0] tvec_i,
    input  logic        mret_i,
    input  logic [31:0] epc_i,
    input  logic        irq_wait_i,
    input  logic        irq_served_i,
    output logic [31:0] pc_o
);

    ev_t   ev;
    nsel_e nsel;
    pc_t   pc_q;
    pc_t   pc_d;
    logic  pend_vld;
    pc_t   pend_tgt;

    always_comb begin
        ev.boot     = rst;
        ev.exc      = exc_i;
        ev.ret      = mret_i;
        ev.irq_srv  = irq_served_i;
        ev.jmp      = br_take_i;
        ev.defer    = br_defer_i;
        ev.issue    = issue_i;
        ev.irq_wait = irq_wait_i;
    end

    pcu_next_sel #(
        .BOOT_ADDR (BOOT_ADDR)
    ) u_sel (
        .ev       (ev),
        .pc_q     (pc_q),
        .pend_vld (pend_vld),
        .pend_tgt (pend_tgt),
        .tvec     (tvec_i),
        .epc      (epc_i),
        .br_tgt   (br_target_i),
        .nsel     (nsel),
        .pc_d     (pc_d)
    );

    pcu_pend_latch u_pend (
        .clk    (clk),
        .rst    (rst),
        .load   (nsel == NS_DEFER),
        .drop   (is_redirect(nsel) || (nsel == NS_RESUME)),
        .tgt_in (br_target_i),
        .vld    (pend_vld),
        .tgt_q  (pend_tgt)
    );

    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/pcu_checks.sv
module pcu_checks
    import pcu_pkg::*;
#(
    parameter logic [31:0] BOOT_ADDR = 32'h0000_0080
) (
    input logic        clk,
    input logic        rst,
    input logic        issue_i,
    input logic        br_take_i,
    input logic        br_defer_i,
    input logic        exc_i,
    input logic [31:0] tvec_i,
    input logic        mret_i,
    input logic [31:0] epc_i,
    input logic        irq_wait_i,
    input logic        irq_served_i,
    input logic        pend_vld,
    input logic [31:0] pc_o
);

    logic any_ev;
    assign any_ev = exc_i | mret_i | irq_served_i | br_take_i | br_defer_i;

    // R1
    boot_load_chk: assert property (@(posedge clk)
        rst |=> pc_o == {BOOT_ADDR[31:2], 2'b00});

    // R2
    step_four_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !any_ev && !irq_wait_i && !pend_vld) |=> pc_o == $past(pc_o) + 32'd4);

    // R3
    trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
        exc_i |=> pc_o == {$past(tvec_i[31:2]), 2'b00});

    // R4
    trap_return_chk: assert property (@(posedge clk) disable iff (rst)
        (mret_i && !exc_i) |=> pc_o == {$past(epc_i[31:2]), 2'b00});

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!issue_i && !any_ev) |=> $stable(pc_o));

    // R10
    word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

endmodule

bind pc_updater_thread pcu_checks #(
    .BOOT_ADDR (BOOT_ADDR)
) u_checks (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue_i),
    .br_take_i    (br_take_i),
    .br_defer_i   (br_defer_i),
    .exc_i        (exc_i),
    .tvec_i       (tvec_i),
    .mret_i       (mret_i),
    .epc_i        (epc_i),
    .irq_wait_i   (irq_wait_i),
    .irq_served_i (irq_served_i),
    .pend_vld     (pend_vld),
    .pc_o         (pc_o)
);

// File: tb/tb_pc_updater_thread.sv
`timescale 1ns/1ps
module tb_pc_updater_thread;

    localparam logic [31:0] BOOT = 32'h0000_0083;
    localparam int CYCLES_MAX = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_i = 1'b0;
    logic        br_take_i = 1'b0;
    logic        br_defer_i = 1'b0;
    logic [31:0] br_target_i = '0;
    logic        exc_i = 1'b0;
    logic [31:0] tvec_i = '0;
    logic        mret_i = 1'b0;
    logic [31:0] epc_i = '0;
    logic        irq_wait_i = 1'b0;
    logic        irq_served_i = 1'b0;
    logic [31:0] pc_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_pc;
    logic        m_pv = 1'b0;
    logic [31:0] m_pt = '0;
    string       tag;

    always #4 clk = ~clk;

    pc_updater_thread #(.BOOT_ADDR(BOOT)) dut (
        .clk(clk), .rst(rst), .issue_i(issue_i), .br_take_i(br_take_i),
        .br_defer_i(br_defer_i), .br_target_i(br_target_i), .exc_i(exc_i),
        .tvec_i(tvec_i), .mret_i(mret_i), .epc_i(epc_i),
        .irq_wait_i(irq_wait_i), .irq_served_i(irq_served_i), .pc_o(pc_o)
    );

    function automatic logic [31:0] al(logic [31:0] a);
        return a & 32'hFFFF_FFFC;
    endfunction

    // Behavioural reference: applies the rules in priority order
    task automatic model();
        if (rst)               begin exp_pc = al(BOOT); m_pv = 1'b0; tag = "R1"; end
        else if (exc_i)        begin exp_pc = al(tvec_i); m_pv = 1'b0; tag = "R3"; end
        else if (mret_i)       begin exp_pc = al(epc_i); m_pv = 1'b0; tag = "R4"; end
        else if (irq_served_i) begin exp_pc = al(tvec_i); m_pv = 1'b0; tag = "R5"; end
        else if (br_take_i)    begin exp_pc = al(br_target_i); m_pv = 1'b0; tag = "R6"; end
        else if (br_defer_i)   begin m_pt = al(br_target_i); m_pv = 1'b1; tag = "R7"; end
        else if (!issue_i)     begin tag = "R9"; end
        else if (irq_wait_i)   begin tag = "R8"; end
        else if (m_pv)         begin exp_pc = m_pt; m_pv = 1'b0; tag = "R7"; end
        else                   begin exp_pc = exp_pc + 32'd4; tag = "R2"; end
    endtask

    task automatic tick();
        model();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pc_o !== exp_pc) begin
            errors++;
            $display("FAIL %s: pc_o=%h expected=%h", tag, pc_o, exp_pc);
        end
        checks++;
        if (pc_o[1:0] !== 2'b00) begin
            errors++;
            $display("FAIL R10: pc_o[1:0]=%b expected=00", pc_o[1:0]);
        end
    endtask

    task automatic clear_ev();
        rst = 0; issue_i = 0; br_take_i = 0; br_defer_i = 0; exc_i = 0;
        mret_i = 0; irq_wait_i = 0; irq_served_i = 0;
    endtask

    initial begin
        exp_pc = '0;
        tvec_i = 32'h0000_1003; epc_i = 32'h0000_2002; br_target_i = 32'h0000_3001;
        tick();                                  // R1 reset value
        tick();
        clear_ev();
        for (int i = 0; i < 4; i++) begin issue_i = 1; tick(); end   // R2
        issue_i = 0; tick(); tick();                                  // R9
        br_take_i = 1; issue_i = 1; tick(); clear_ev();               // R6
        issue_i = 1; tick();
        br_defer_i = 1; br_target_i = 32'h0000_4007; tick(); clear_ev(); // R7 store
        tick();                                   // held, no issue
        issue_i = 1; irq_wait_i = 1; tick();      // R8 stall keeps store
        irq_wait_i = 0; tick();                   // R7 resume
        tick();                                   // R2 after resume
        br_defer_i = 1; tick(); clear_ev();
        exc_i = 1; tick(); clear_ev();            // R3 discards store
        issue_i = 1; tick();                      // must step, not resume
        exc_i = 1; mret_i = 1; irq_served_i = 1; br_take_i = 1; tick(); clear_ev(); // R3 priority
        mret_i = 1; irq_served_i = 1; br_take_i = 1; tick(); clear_ev();            // R4 priority
        irq_served_i = 1; br_take_i = 1; br_defer_i = 1; tick(); clear_ev();        // R5 priority
        issue_i = 1; tick();
        tvec_i = 32'hFFFF_FFFF; exc_i = 1; tick(); clear_ev();
        issue_i = 1; tick(); tick();              // R2 wrap
        rst = 1; issue_i = 1; exc_i = 1; tick(); clear_ev(); // R1 priority
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            rst          = (r == 0);
            exc_i        = ($urandom_range(0, 29) == 0);
            mret_i       = ($urandom_range(0, 24) == 0);
            irq_served_i = ($urandom_range(0, 24) == 0);
            br_take_i    = ($urandom_range(0, 9) == 0);
            br_defer_i   = ($urandom_range(0, 9) == 0);
            issue_i      = ($urandom_range(0, 2) != 0);
            irq_wait_i   = ($urandom_range(0, 7) == 0);
            br_target_i  = $urandom;
            tvec_i       = $urandom;
            epc_i        = $urandom;
            tick();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * CYCLES_MAX);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule